// File: doc/BRIEF.md
# Multicycle 16-bit Instruction Controller

This block sequences a small 16-bit register machine one instruction at a time. It holds the program counter, the instruction register, the memory address and memory data registers, two operand latches and a result latch. It owns an eight-entry register file and a three-function ALU (add, bitwise AND, invert). Each instruction passes through up to six phases: fetch, decode, address evaluation, operand fetch, execute and result store. Phases that an opcode does not need are skipped, so the cycle count depends on the instruction.

Memory sits outside the block. The block presents an address and a read strobe, and it expects the read word back within the same cycle. The register-file write bus is brought out so that the surrounding logic can trace each result. The phase code and the program counter are also visible. A run-enable input gates every state change, and holding it low freezes the machine until it returns high.

Top module: `cpu16_mc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset release, `pc_o` is 0, `phase_o` is 0 (fetch), `mem_rd` is 0, `wb_en` is 0, and every general register reads 0.
- R2: Fetch takes three enabled cycles. In the second cycle `mem_rd` is 1, `mem_addr` equals the old PC and `pc_o` equals the old PC plus 1 (modulo 2^16). After the third cycle `ir_o` holds the word read and `phase_o` is 1 (decode).
- R3: Opcode 0001 (add) writes `src1 + src2` modulo 2^16 to the destination. The destination is in bits [11:9] and src1 is the register in bits [8:6]. When bit 5 is 1, src2 is bits [4:0] sign-extended; when bit 5 is 0, src2 is the register in bits [2:0].
- R4: Opcode 0101 (and) writes `src1 & src2`. It uses the same fields and immediate rule as R3.
- R5: Opcode 1001 (invert) writes the bitwise complement of the register in bits [8:6] to the register in bits [11:9].
- R6: Opcode 0110 (load) forms an address as the register in bits [8:6] plus bits [5:0] sign-extended. It presents that address with `mem_rd` high for two cycles and writes the returned word to the register in bits [11:9].
- R7: Opcode 1100 (jump) sets the PC to the register in bits [8:6], and the next fetch reads from that address.
- R8: Any other opcode writes no register and returns to fetch right after decode.
- R9: An instruction occupies exactly 7 enabled cycles for add, and and invert, 8 for load, 5 for jump and 4 for any other opcode, counted from its first fetch cycle to the next fetch. `phase_o` codes are 0 fetch, 1 decode, 2 address, 3 operand, 4 execute, 5 store.
- R10: While `run_en` is low, `pc_o`, `ir_o`, `phase_o`, `mem_addr` and `mem_rd` hold their values and `wb_en` stays 0.
- R11: Each add, and, invert or load instruction raises `wb_en` for exactly one enabled cycle, in the store phase. Jump and unknown opcodes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Run enable; low freezes all state |
| mem_addr | output | 16 | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Word returned by memory for `mem_addr` in the same cycle |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |
| phase_o | output | 3 | Current phase code |
| wb_en | output | 1 | Register-file write strobe |
| wb_dst | output | 3 | Register-file write index |
| wb_data | output | 16 | Register-file write data |

## Verification
The bench builds the block with its default parameters: a 16-bit word and eight registers. With this setting every field position and immediate sign extension is exercised as specified, and the add results wrap at 2^16. The bench memory holds 1024 words, indexed by the low address bits. Jumps to random register values therefore land anywhere in the 16-bit PC range while still fetching predictable words, and load addresses built from negative offsets alias safely back into the array.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  typedef enum logic [3:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_FETCH_LOAD,
    ST_DECODE,
    ST_EVAL,
    ST_LD_WAIT,
    ST_LD_CAPT,
    ST_OPND,
    ST_EXEC,
    ST_STORE
  } ctrl_state_e;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EVAL   = 3'd2,
    PH_OPND   = 3'd3,
    PH_EXEC   = 3'd4,
    PH_STORE  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_AND,
    ALU_INV,
    ALU_PASS
  } alu_op_e;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_INV = 4'b1001;
  localparam logic [3:0] OPC_LDR = 4'b0110;
  localparam logic [3:0] OPC_JMP = 4'b1100;

  function automatic phase_e phase_of(ctrl_state_e s);
    phase_e p;
    case (s)
      ST_DECODE:              p = PH_DECODE;
      ST_EVAL:                p = PH_EVAL;
      ST_LD_WAIT, ST_LD_CAPT,
      ST_OPND:                p = PH_OPND;
      ST_EXEC:                p = PH_EXEC;
      ST_STORE:               p = PH_STORE;
      default:                p = PH_FETCH;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cpu16_rst_sync.sv
module cpu16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter  int DATA_W  = 16,
  parameter  int REG_CNT = 8,
  localparam int REG_AW  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] regs_q [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == REG_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (hit) regs_q[g] <= wdata;
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

  // a write lands in the addressed entry on the next cycle
  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_INV: y = ~a;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
#(
  parameter  int DATA_W  = 16,
  parameter  int REG_CNT = 8,
  localparam int REG_AW  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [REG_AW-1:0] rf_raddr_a,
  output logic [REG_AW-1:0] rf_raddr_b,
  input  logic [DATA_W-1:0] rf_rdata_a,
  input  logic [DATA_W-1:0] rf_rdata_b,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_dst,
  output logic [DATA_W-1:0] wb_data,
  output alu_op_e           alu_op,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_y,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output phase_e            phase
);

  localparam int OPC_LSB = DATA_W - 4;
  localparam int DST_LSB = 9;
  localparam int SR1_LSB = 6;
  localparam int SR2_LSB = 0;
  localparam int IMM_SEL = 5;

  ctrl_state_e       state_q, state_d;
  logic [DATA_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q, ir_d;
  logic [DATA_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d;
  logic [DATA_W-1:0] opa_q, opa_d;
  logic [DATA_W-1:0] opb_q, opb_d;
  logic [DATA_W-1:0] res_q, res_d;

  logic [3:0]        opc;
  logic              is_alu;
  logic [DATA_W-1:0] imm5;
  logic [DATA_W-1:0] off6;

  assign opc    = ir_q[OPC_LSB +: 4];
  assign is_alu = (opc == OPC_ADD) || (opc == OPC_AND) || (opc == OPC_INV);
  assign imm5   = {{(DATA_W-5){ir_q[4]}}, ir_q[4:0]};
  assign off6   = {{(DATA_W-6){ir_q[5]}}, ir_q[5:0]};

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH_ADDR: state_d = ST_FETCH_READ;
      ST_FETCH_READ: state_d = ST_FETCH_LOAD;
      ST_FETCH_LOAD: state_d = ST_DECODE;
      ST_DECODE: begin
        if (is_alu)              state_d = ST_OPND;
        else if (opc == OPC_LDR) state_d = ST_EVAL;
        else if (opc == OPC_JMP) state_d = ST_EXEC;
        else                     state_d = ST_FETCH_ADDR;
      end
      ST_EVAL:    state_d = ST_LD_WAIT;
      ST_LD_WAIT: state_d = ST_LD_CAPT;
      ST_LD_CAPT: state_d = ST_STORE;
      ST_OPND:    state_d = ST_EXEC;
      ST_EXEC:    state_d = (opc == OPC_JMP) ? ST_FETCH_ADDR : ST_STORE;
      ST_STORE:   state_d = ST_FETCH_ADDR;
      default:    state_d = ST_FETCH_ADDR;
    endcase
  end

  // datapath next values
  always_comb begin
    pc_d  = pc_q;
    ir_d  = ir_q;
    mar_d = mar_q;
    mdr_d = mdr_q;
    opa_d = opa_q;
    opb_d = opb_q;
    res_d = res_q;
    case (state_q)
      ST_FETCH_ADDR: begin
        mar_d = pc_q;
        pc_d  = pc_q + DATA_W'(1);
      end
      ST_FETCH_READ: mdr_d = mem_rdata;
      ST_FETCH_LOAD: ir_d  = mdr_q;
      ST_EVAL:       mar_d = rf_rdata_a + off6;
      ST_LD_CAPT:    mdr_d = mem_rdata;
      ST_OPND: begin
        opa_d = rf_rdata_a;
        opb_d = ir_q[IMM_SEL] ? imm5 : rf_rdata_b;
      end
      ST_EXEC: begin
        if (opc == OPC_JMP) pc_d  = rf_rdata_a;
        else                res_d = alu_y;
      end
      default: ;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH_ADDR;
      pc_q    <= '0;
      ir_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      res_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      mar_q   <= mar_d;
      mdr_q   <= mdr_d;
      opa_q   <= opa_d;
      opb_q   <= opb_d;
      res_q   <= res_d;
    end
  end

  always_comb begin
    case (opc)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_AND: alu_op = ALU_AND;
      OPC_INV: alu_op = ALU_INV;
      default: alu_op = ALU_PASS;
    endcase
  end

  assign alu_a      = opa_q;
  assign alu_b      = opb_q;
  assign rf_raddr_a = ir_q[SR1_LSB +: REG_AW];
  assign rf_raddr_b = ir_q[SR2_LSB +: REG_AW];
  assign wb_en      = en && (state_q == ST_STORE);
  assign wb_dst     = ir_q[DST_LSB +: REG_AW];
  assign wb_data    = (opc == OPC_LDR) ? mdr_q : res_q;
  assign mem_addr   = mar_q;
  assign mem_rd     = (state_q == ST_FETCH_READ) || (state_q == ST_LD_WAIT) ||
                      (state_q == ST_LD_CAPT);
  assign pc         = pc_q;
  assign ir         = ir_q;
  assign phase      = phase_of(state_q);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q) && $stable(pc_q) && $stable(ir_q) && $stable(mar_q));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ST_FETCH_ADDR) |=> pc_q == $past(pc_q) + DATA_W'(1));

  assert_ir_only_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FETCH_LOAD) |=> $stable(ir_q));

  assert_unknown_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ST_DECODE && !is_alu && opc != OPC_LDR && opc != OPC_JMP)
      |=> state_q == ST_FETCH_ADDR);

  assert_ld_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ST_LD_WAIT) |=> mem_rd && $stable(mar_q));

  assert_wb_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);

endmodule

// File: rtl/cpu16_mc.sv
module cpu16_mc
  import cpu16_pkg::*;
#(
  parameter  int DATA_W  = 16,
  parameter  int REG_CNT = 8,
  localparam int REG_AW  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [2:0]        phase_o,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_dst,
  output logic [DATA_W-1:0] wb_data
);

  logic              rst_sync_n;
  logic [REG_AW-1:0] raddr_a, raddr_b;
  logic [DATA_W-1:0] rdata_a, rdata_b;
  alu_op_e           alu_op;
  logic [DATA_W-1:0] alu_a, alu_b, alu_y;
  phase_e            phase;

  cpu16_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  cpu16_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) i_regfile (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (wb_en),
    .waddr   (wb_dst),
    .wdata   (wb_data),
    .raddr_a (raddr_a),
    .rdata_a (rdata_a),
    .raddr_b (raddr_b),
    .rdata_b (rdata_b)
  );

  cpu16_alu #(.DATA_W(DATA_W)) i_alu (
    .op (alu_op),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  cpu16_ctrl #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (run_en),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .rf_raddr_a (raddr_a),
    .rf_raddr_b (raddr_b),
    .rf_rdata_a (rdata_a),
    .rf_rdata_b (rdata_b),
    .wb_en      (wb_en),
    .wb_dst     (wb_dst),
    .wb_data    (wb_data),
    .alu_op     (alu_op),
    .alu_a      (alu_a),
    .alu_b      (alu_b),
    .alu_y      (alu_y),
    .pc         (pc_o),
    .ir         (ir_o),
    .phase      (phase)
  );

  assign phase_o = phase;

endmodule

// File: tb/test_cpu16_mc.sv
module test_cpu16_mc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata;
  logic [15:0] pc_o;
  logic [15:0] ir_o;
  logic [2:0]  phase_o;
  logic        wb_en;
  logic [2:0]  wb_dst;
  logic [15:0] wb_data;

  logic [15:0] mem [1024];
  logic [15:0] mreg [8];
  logic [15:0] mpc;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];

  cpu16_mc i_cpu16_mc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .ir_o(ir_o), .phase_o(phase_o),
    .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] sx5(input logic [15:0] i);
    return {{11{i[4]}}, i[4:0]};
  endfunction

  function automatic logic [15:0] sx6(input logic [15:0] i);
    return {{10{i[5]}}, i[5:0]};
  endfunction

  function automatic int inst_len(input logic [3:0] op);
    case (op)
      4'b0001, 4'b0101, 4'b1001: return 7;
      4'b0110:                   return 8;
      4'b1100:                   return 5;
      default:                   return 4;
    endcase
  endfunction

  function automatic string op_req(input logic [3:0] op);
    case (op)
      4'b0001: return "R3";
      4'b0101: return "R4";
      4'b1001: return "R5";
      4'b0110: return "R6";
      4'b1100: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic stall(input int n);
    logic [15:0] s_pc, s_ir, s_addr;
    logic [2:0]  s_ph;
    logic        s_rd;
    run_en = 1'b0;
    s_pc = pc_o; s_ir = ir_o; s_addr = mem_addr; s_ph = phase_o; s_rd = mem_rd;
    for (int k = 0; k < n; k++) begin
      tick();
      chk("R10", "pc frozen", pc_o, s_pc);
      chk("R10", "ir frozen", ir_o, s_ir);
      chk("R10", "addr frozen", mem_addr, s_addr);
      chk("R10", "phase frozen", {13'b0, phase_o}, {13'b0, s_ph});
      chk("R10", "rd frozen", {15'b0, mem_rd}, {15'b0, s_rd});
      chk("R10", "no write", {15'b0, wb_en}, 16'h0);
    end
    run_en = 1'b1;
  endtask

  task automatic run_instr(input logic [15:0] ins, input int stall_at);
    logic [3:0]  op;
    logic [2:0]  dr, s1, s2;
    logic [15:0] b, data, nxt, ea;
    int          len, wbn, exp_wb;
    string       rq;
    op = ins[15:12]; dr = ins[11:9]; s1 = ins[8:6]; s2 = ins[2:0];
    rq = op_req(op);
    len = inst_len(op);
    mem[mpc[9:0]] = ins;
    b = ins[5] ? sx5(ins) : mreg[s2];
    ea = mreg[s1] + sx6(ins);
    nxt = mpc + 16'd1;
    exp_wb = 1;
    data = '0;
    case (op)
      4'b0001: data = mreg[s1] + b;
      4'b0101: data = mreg[s1] & b;
      4'b1001: data = ~mreg[s1];
      4'b0110: data = mem[ea[9:0]];
      4'b1100: begin nxt = mreg[s1]; exp_wb = 0; end
      default: exp_wb = 0;
    endcase
    chk("R2", "start in fetch", {13'b0, phase_o}, 16'h0);
    chk("R2", "pc at start", pc_o, mpc);
    wbn = 0;
    for (int c = 1; c <= len; c++) begin
      if (c == stall_at) stall(3);
      tick();
      if (wb_en) begin
        wbn++;
        chk(rq, "write index", {13'b0, wb_dst}, {13'b0, dr});
        chk(rq, "write data", wb_data, data);
        chk("R11", "write in store", {13'b0, phase_o}, 16'd5);
      end
      if (c == 1) begin
        chk("R2", "fetch read", {15'b0, mem_rd}, 16'h1);
        chk("R2", "fetch addr", mem_addr, mpc);
        chk("R2", "pc plus one", pc_o, mpc + 16'd1);
      end
      if (c == 3) begin
        chk("R2", "ir loaded", ir_o, ins);
        chk("R2", "decode phase", {13'b0, phase_o}, 16'h1);
      end
      if (op == 4'b0110 && c == 5) begin
        chk("R6", "load addr", mem_addr, ea);
        chk("R6", "load read", {15'b0, mem_rd}, 16'h1);
      end
      if (c == len - 1)
        chk("R9", "not yet fetch", {15'b0, phase_o != 3'd0}, 16'h1);
    end
    chk("R9", "back to fetch", {13'b0, phase_o}, 16'h0);
    chk("R9", "fetch start no read", {15'b0, mem_rd}, 16'h0);
    chk((op == 4'b1100) ? "R7" : "R2", "next pc", pc_o, nxt);
    chk((exp_wb == 1) ? "R11" : "R8", "write count", 16'(wbn), 16'(exp_wb));
    if (exp_wb == 1) mreg[dr] = data;
    mpc = nxt;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk("R1", "pc in reset", pc_o, 16'h0);
    chk("R1", "phase in reset", {13'b0, phase_o}, 16'h0);
    chk("R1", "no read in reset", {15'b0, mem_rd}, 16'h0);
    chk("R1", "no write in reset", {15'b0, wb_en}, 16'h0);
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick();
    chk("R1", "pc after release", pc_o, 16'h0);
    chk("R1", "phase after release", {13'b0, phase_o}, 16'h0);
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0;
    mpc = 16'h0;
  endtask

  function automatic logic [15:0] rand_instr();
    logic [15:0] w;
    int k;
    w = 16'($urandom);
    k = $urandom_range(0, 9);
    case (k)
      0, 1: w[15:12] = 4'b0001;
      2, 3: w[15:12] = 4'b0101;
      4:    w[15:12] = 4'b1001;
      5, 6: w[15:12] = 4'b0110;
      7:    w[15:12] = 4'b1100;
      default: begin
        while (w[15:12] == 4'b0001 || w[15:12] == 4'b0101 || w[15:12] == 4'b1001 ||
               w[15:12] == 4'b0110 || w[15:12] == 4'b1100)
          w[15:12] = 4'($urandom);
      end
    endcase
    return w;
  endfunction

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
    mem[10] = 16'hFFFF;
    mem[11] = 16'h8001;
    run_en = 1'b1;
    do_reset();
    // R1: registers read zero after reset
    run_instr(16'b0001_001_010_0_00_011, 0);
    // R6: load constants, base R0 = 0, positive offsets
    run_instr(16'b0110_001_000_001010, 0);
    run_instr(16'b0110_010_000_001011, 2);
    for (int r = 3; r < 8; r++)
      run_instr({4'b0110, 3'(r), 3'b000, 6'(20 + r)}, 0);
    // R6: negative offset from a nonzero base
    run_instr(16'b0110_011_010_100000, 6);
    // R3: wrap and immediate extremes
    run_instr(16'b0001_100_001_0_00_010, 0);
    run_instr(16'b0001_101_001_1_10000, 0);
    run_instr(16'b0001_101_101_1_01111, 7);
    // R4: immediate and register forms
    run_instr(16'b0101_110_010_1_10101, 0);
    run_instr(16'b0101_111_001_0_00_010, 0);
    // R5
    run_instr(16'b1001_000_001_111111, 4);
    // R8: unknown opcodes
    run_instr(16'h0FFF, 0);
    run_instr(16'hF000, 3);
    // R7: jump then continue
    run_instr(16'b1100_000_100_000000, 0);
    run_instr(16'b0001_001_001_1_00001, 0);
    // random stream
    for (int n = 0; n < 400; n++)
      run_instr(rand_instr(), ($urandom_range(0, 7) == 0) ? $urandom_range(1, 4) : 0);
    // R1: reset mid-run clears state
    do_reset();
    run_instr(16'b0101_010_011_0_00_100, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule